// File: doc/BRIEF.md
# Configuration transaction control engine

This block runs configuration commands for a board-level system controller. Software sees three 32-bit registers. An operand register sits at offset 0xA0, a command register at 0xA4 and a result-status register at 0xA8. To issue a command, software first loads the operand register. It then writes the command register with the launch bit (bit 31) set. In the same cycle the engine decodes the packed command. It then does one of three things: reads or rewrites an oscillator frequency entry, reads a voltage sensor, or accepts an action such as a shutdown or reboot request.

The oscillator store holds a fixed set of motherboard entries and a parameterised set of daughterboard entries. The daughterboard sensor voltages are parameters. Completion and failure are reported in the status register. A successful read replaces the operand register with the result. A strap input states whether this board variant carries the registers. When it is low, all three offsets read as zero and ignore writes.

Top module: `cfg_txn_engine`

## Requirements
- R1: After reset, the operand, command and status registers read 0 and both request pulses are low. The motherboard oscillators hold 50000000, 23750000, 24000000, 24000000, 24000000 and 24000000 for devices 0 to 5. Daughterboard oscillators hold their parameter values.
- R2: A write to the command register stores the word with bit 31 and bits 19:18 cleared, so the launch bit always reads 0. Fields: bit 30 direction (1 = write), bits 29:26 controller, bits 25:20 function, bits 17:16 site, bits 15:12 position, bits 11:0 device.
- R3: A command write with bit 31 set leaves status 1 on success and 3 on failure (bit 0 = done, bit 1 = error).
- R4: A successful read command loads the result into the operand register. A failed read, and any cycle without an operand write or launch, leaves the operand register unchanged.
- R5: An oscillator command (function 1) reads the entry, or writes the entry from the operand register. Site 0 selects motherboard devices; site 1 selects daughterboard devices.
- R6: A command fails unless the controller is 0, the position is 0 and the site is 0 or 1.
- R7: An oscillator command with a device index at or above the table size of its site fails, and no entry changes.
- R8: A voltage read (function 2) returns 3300000 for site 0 device 0. For site 1 it returns the parameter value of the sensor. It fails for a sensor index beyond the count, for any other site 0 device, and for any write.
- R9: Functions 7 (video mux), 8 (shutdown), 9 (reboot) and 11 (display mode) succeed only as writes to site 0 device 0. Every other function code fails.
- R10: A successful shutdown or reboot command raises shutdown_o or reboot_o for exactly the one cycle after the command write.
- R11: A write to the status register keeps only bits 1:0.
- R12: With board_en_i low, rdata_o is 0 and writes change no register and launch nothing.
- R13: A command write without bit 31 leaves the status and operand registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| board_en_i | input | 1 | Board variant carries the registers |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Byte offset of the access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| shutdown_o | output | 1 | One-cycle shutdown request |
| reboot_o | output | 1 | One-cycle reboot request |

## Verification
Two things can fall in the same cycle: the request pulse of one command and the decode and write-back of the next command. Every command finishes on its own write edge, so a second command can be written on the very next clock. The bench issues a shutdown command and follows it at once with an oscillator read. It then checks three things: the shutdown pulse is high while the second command is presented, the pulse falls after one cycle, and the read still reports status 1 with the correct frequency in the operand register.

// File: rtl/cfg_txn_pkg.sv
package cfg_txn_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned AW = 8;

  localparam logic [AW-1:0] OFF_DATA = 8'hA0;
  localparam logic [AW-1:0] OFF_CTRL = 8'hA4;
  localparam logic [AW-1:0] OFF_STAT = 8'hA8;

  // bits dropped when the command word is stored
  localparam logic [DW-1:0] CTRL_DROP = 32'h800C_0000;

  localparam logic [DW-1:0] MB_VOLT = 32'd3300000;

  typedef enum logic [5:0] {
    FN_OSC  = 6'd1,
    FN_VOLT = 6'd2,
    FN_MUX  = 6'd7,
    FN_OFF  = 6'd8,
    FN_BOOT = 6'd9,
    FN_DVI  = 6'd11
  } fn_e;

  typedef struct packed {
    logic        go;
    logic        wr;
    logic [3:0]  ctl;
    logic [5:0]  fn;
    logic [1:0]  rsv;
    logic [1:0]  site;
    logic [3:0]  pos;
    logic [11:0] dev;
  } cmd_t;

  function automatic logic [DW-1:0] mb_osc_rst(int unsigned idx);
    if (idx == 0) return 32'd50000000;
    if (idx == 1) return 32'd23750000;
    return 32'd24000000;
  endfunction
endpackage

// File: rtl/cfg_cmd_decode.sv
module cfg_cmd_decode
  import cfg_txn_pkg::*;
#(
  parameter int unsigned MB_OSC = 6,
  parameter int unsigned DB_OSC = 3,
  parameter int unsigned DB_VS  = 2,
  localparam int unsigned NOSC  = MB_OSC + DB_OSC,
  localparam int unsigned OIW   = (NOSC > 1) ? $clog2(NOSC) : 1,
  localparam int unsigned VIW   = (DB_VS > 1) ? $clog2(DB_VS) : 1
) (
  input  cmd_t           cmd_i,
  output logic           ok_o,
  output logic           osc_sel_o,
  output logic [OIW-1:0] osc_idx_o,
  output logic           volt_mb_o,
  output logic [VIW-1:0] volt_idx_o,
  output logic           off_o,
  output logic           boot_o
);
  logic route_ok, hit, at_mb, at_db, mb_dev0;
  int unsigned dev;

  always_comb begin
    dev      = 32'(cmd_i.dev);
    at_mb    = (cmd_i.site == 2'd0);
    at_db    = (cmd_i.site == 2'd1);
    mb_dev0  = at_mb && (cmd_i.dev == '0);
    route_ok = (cmd_i.ctl == '0) && (cmd_i.pos == '0) && (at_mb || at_db);
    hit        = 1'b0;
    osc_sel_o  = 1'b0;
    osc_idx_o  = '0;
    volt_mb_o  = 1'b0;
    volt_idx_o = '0;
    off_o      = 1'b0;
    boot_o     = 1'b0;
    case (cmd_i.fn)
      FN_OSC: begin
        if (at_mb && dev < MB_OSC) begin
          hit = 1'b1; osc_sel_o = 1'b1; osc_idx_o = OIW'(dev);
        end else if (at_db && dev < DB_OSC) begin
          hit = 1'b1; osc_sel_o = 1'b1; osc_idx_o = OIW'(MB_OSC + dev);
        end
      end
      FN_VOLT: begin
        if (!cmd_i.wr) begin
          if (mb_dev0) begin
            hit = 1'b1; volt_mb_o = 1'b1;
          end else if (at_db && dev < DB_VS) begin
            hit = 1'b1; volt_idx_o = VIW'(dev);
          end
        end
      end
      FN_MUX, FN_DVI: hit = cmd_i.wr && mb_dev0;
      FN_OFF: begin
        hit = cmd_i.wr && mb_dev0; off_o = hit;
      end
      FN_BOOT: begin
        hit = cmd_i.wr && mb_dev0; boot_o = hit;
      end
      default: hit = 1'b0;
    endcase
    ok_o = route_ok && hit;
  end
endmodule

// File: rtl/cfg_osc_bank.sv
module cfg_osc_bank
  import cfg_txn_pkg::*;
#(
  parameter int unsigned MB_OSC = 6,
  parameter int unsigned DB_OSC = 3,
  parameter logic [DB_OSC*DW-1:0] DB_OSC_RST = {32'd33333333, 32'd40000000, 32'd60000000},
  localparam int unsigned NOSC = MB_OSC + DB_OSC,
  localparam int unsigned OIW  = (NOSC > 1) ? $clog2(NOSC) : 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           we_i,
  input  logic [OIW-1:0] idx_i,
  input  logic [DW-1:0]  wdata_i,
  output logic [DW-1:0]  rdata_o
);
  logic [DW-1:0] ent_q [NOSC];

  for (genvar g = 0; g < NOSC; g++) begin : g_ent
    localparam logic [DW-1:0] RV = (g < MB_OSC) ? mb_osc_rst(g)
                                                : DB_OSC_RST[((g >= MB_OSC) ? (g - MB_OSC) : 0)*DW +: DW];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ent_q[g] <= RV;
      else if (we_i && (32'(idx_i) == g)) ent_q[g] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NOSC; i++) begin
      if (32'(idx_i) == i) rdata_o = ent_q[i];
    end
  end
endmodule

// File: rtl/cfg_volt_src.sv
module cfg_volt_src
  import cfg_txn_pkg::*;
#(
  parameter int unsigned DB_VS = 2,
  parameter logic [DB_VS*DW-1:0] DB_VOLT = {32'd1000000, 32'd900000},
  localparam int unsigned VIW = (DB_VS > 1) ? $clog2(DB_VS) : 1
) (
  input  logic           mb_i,
  input  logic [VIW-1:0] idx_i,
  output logic [DW-1:0]  val_o
);
  always_comb begin
    val_o = '0;
    if (mb_i) val_o = MB_VOLT;
    else begin
      for (int i = 0; i < DB_VS; i++) begin
        if (32'(idx_i) == i) val_o = DB_VOLT[i*DW +: DW];
      end
    end
  end
endmodule

// File: rtl/cfg_txn_engine.sv
module cfg_txn_engine
  import cfg_txn_pkg::*;
#(
  parameter int unsigned MB_OSC = 6,
  parameter int unsigned DB_OSC = 3,
  parameter int unsigned DB_VS  = 2,
  parameter logic [DB_OSC*32-1:0] DB_OSC_RST = {32'd33333333, 32'd40000000, 32'd60000000},
  parameter logic [DB_VS*32-1:0]  DB_VOLT    = {32'd1000000, 32'd900000},
  localparam int unsigned NOSC = MB_OSC + DB_OSC,
  localparam int unsigned OIW  = (NOSC > 1) ? $clog2(NOSC) : 1,
  localparam int unsigned VIW  = (DB_VS > 1) ? $clog2(DB_VS) : 1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        board_en_i,
  input  logic        wr_i,
  input  logic [7:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        shutdown_o,
  output logic        reboot_o
);
  logic [DW-1:0] data_q, ctrl_q;
  logic [1:0]    stat_q;
  logic          off_q, boot_q;

  logic          acc, wr_data, wr_ctrl, wr_stat, txn;
  cmd_t          cmd;
  logic          ok, osc_sel, volt_mb, dec_off, dec_boot;
  logic [OIW-1:0] osc_idx;
  logic [VIW-1:0] volt_idx;
  logic [DW-1:0] osc_val, volt_val, rd_val;
  logic          osc_we;

  assign acc     = wr_i && board_en_i;
  assign wr_data = acc && (addr_i == OFF_DATA);
  assign wr_ctrl = acc && (addr_i == OFF_CTRL);
  assign wr_stat = acc && (addr_i == OFF_STAT);
  assign cmd     = cmd_t'(wdata_i);
  assign txn     = wr_ctrl && cmd.go;

  cfg_cmd_decode #(.MB_OSC(MB_OSC), .DB_OSC(DB_OSC), .DB_VS(DB_VS)) i_dec (
    .cmd_i      (cmd),
    .ok_o       (ok),
    .osc_sel_o  (osc_sel),
    .osc_idx_o  (osc_idx),
    .volt_mb_o  (volt_mb),
    .volt_idx_o (volt_idx),
    .off_o      (dec_off),
    .boot_o     (dec_boot)
  );

  assign osc_we = txn && cmd.wr && ok && osc_sel;

  cfg_osc_bank #(.MB_OSC(MB_OSC), .DB_OSC(DB_OSC), .DB_OSC_RST(DB_OSC_RST)) i_osc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (osc_we),
    .idx_i   (osc_idx),
    .wdata_i (data_q),
    .rdata_o (osc_val)
  );

  cfg_volt_src #(.DB_VS(DB_VS), .DB_VOLT(DB_VOLT)) i_volt (
    .mb_i  (volt_mb),
    .idx_i (volt_idx),
    .val_o (volt_val)
  );

  assign rd_val = osc_sel ? osc_val : volt_val;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      ctrl_q <= '0;
      stat_q <= '0;
      off_q  <= 1'b0;
      boot_q <= 1'b0;
    end else begin
      if (wr_data) data_q <= wdata_i;
      else if (txn && !cmd.wr && ok) data_q <= rd_val;
      if (wr_ctrl) ctrl_q <= wdata_i & ~CTRL_DROP;
      if (txn) stat_q <= {~ok, 1'b1};
      else if (wr_stat) stat_q <= wdata_i[1:0];
      off_q  <= txn && cmd.wr && ok && dec_off;
      boot_q <= txn && cmd.wr && ok && dec_boot;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (board_en_i) begin
      case (addr_i)
        OFF_DATA: rdata_o = data_q;
        OFF_CTRL: rdata_o = ctrl_q;
        OFF_STAT: rdata_o = {30'd0, stat_q};
        default:  rdata_o = '0;
      endcase
    end
  end

  assign shutdown_o = off_q;
  assign reboot_o   = boot_q;
endmodule

// File: rtl/cfg_txn_engine_chk.sv
module cfg_txn_engine_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        board_en_i,
  input logic        wr_i,
  input logic [7:0]  addr_i,
  input logic [31:0] wdata_i,
  input logic [31:0] rdata_o,
  input logic        shutdown_o,
  input logic        reboot_o,
  input logic [31:0] data_q,
  input logic [1:0]  stat_q
);
  logic launch;
  assign launch = wr_i && board_en_i && (addr_i == 8'hA4) && wdata_i[31];

  p_done_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch |=> stat_q[0]);

  p_data_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(launch || (wr_i && board_en_i && addr_i == 8'hA0)) |=> $stable(data_q));

  p_off_src_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shutdown_o |-> $past(launch && wdata_i[30] && wdata_i[25:20] == 6'd8));

  p_boot_src_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reboot_o |-> $past(launch && wdata_i[30] && wdata_i[25:20] == 6'd9));

  p_req_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(shutdown_o && reboot_o));

  p_absent_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !board_en_i |-> rdata_o == 32'd0);
endmodule

bind cfg_txn_engine cfg_txn_engine_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .board_en_i (board_en_i),
  .wr_i       (wr_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .shutdown_o (shutdown_o),
  .reboot_o   (reboot_o),
  .data_q     (data_q),
  .stat_q     (stat_q)
);

// File: tb/test_cfg_txn_engine.sv
module test_cfg_txn_engine;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        board_en_i = 1'b1;
  logic        wr_i = 1'b0;
  logic [7:0]  addr_i = 8'h00;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        shutdown_o, reboot_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  localparam logic [7:0] A_DAT = 8'hA0, A_CMD = 8'hA4, A_STA = 8'hA8;

  always #10 clk_i = ~clk_i;

  cfg_txn_engine i_cfg_txn_engine (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(bit go, bit w, int ctl, int fn, int site, int pos, int dev);
    return {go, w, 4'(ctl), 6'(fn), 2'b00, 2'(site), 4'(pos), 12'(dev)};
  endfunction

  task automatic bus_wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk_i);
    wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic bus_rd(logic [7:0] a, output logic [31:0] v);
    addr_i = a;
    #1 v = rdata_o;
  endtask

  task automatic run(logic [31:0] cmdw, logic [31:0] exp_stat, logic [31:0] exp_dat, string req);
    logic [31:0] v;
    bus_wr(A_CMD, cmdw);
    bus_rd(A_STA, v); chk(req, v, exp_stat);
    bus_rd(A_DAT, v); chk(req, v, exp_dat);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    bus_rd(A_DAT, v); chk("R1 data", v, 0);
    bus_rd(A_CMD, v); chk("R1 cmd", v, 0);
    bus_rd(A_STA, v); chk("R1 stat", v, 0);
    chk("R1 pulses", {30'd0, shutdown_o, reboot_o}, 0);
    run(mk(1,0,0,1,0,0,0), 1, 50000000, "R1 mb0");
    run(mk(1,0,0,1,0,0,1), 1, 23750000, "R1 mb1");
    for (int i = 2; i < 6; i++) run(mk(1,0,0,1,0,0,i), 1, 24000000, "R1 mb");
    run(mk(1,0,0,1,1,0,0), 1, 60000000, "R1 db0");
    run(mk(1,0,0,1,1,0,2), 1, 33333333, "R1 db2");
  endtask

  task automatic t_ctrl_mask;
    logic [31:0] v;
    bus_wr(A_STA, 0);
    bus_wr(A_DAT, 32'h0000_1234);
    bus_wr(A_CMD, 32'h7FFF_FFFF);
    bus_rd(A_CMD, v); chk("R2 mask", v, 32'h7FF3_FFFF);
    bus_rd(A_STA, v); chk("R13 no launch stat", v, 0);
    bus_rd(A_DAT, v); chk("R13 no launch data", v, 32'h1234);
    bus_wr(A_CMD, mk(1,0,0,1,0,0,3) | 32'h000C_0000);
    bus_rd(A_CMD, v); chk("R2 go clear", v, mk(0,0,0,1,0,0,3));
  endtask

  task automatic t_osc;
    bus_wr(A_DAT, 32'd12345678);
    run(mk(1,1,0,1,0,0,2), 1, 12345678, "R5 mb wr");
    bus_wr(A_DAT, 0);
    run(mk(1,0,0,1,0,0,2), 1, 12345678, "R5 mb rd");
    run(mk(1,0,0,1,0,0,3), 1, 24000000, "R5 mb neighbour");
    bus_wr(A_DAT, 32'd77000000);
    run(mk(1,1,0,1,1,0,1), 1, 77000000, "R5 db wr");
    bus_wr(A_DAT, 0);
    run(mk(1,0,0,1,1,0,1), 1, 77000000, "R5 db rd");
  endtask

  task automatic t_route;
    bus_wr(A_DAT, 32'h0000_AAAA);
    run(mk(1,0,1,1,0,0,0), 3, 32'hAAAA, "R6 ctl");
    run(mk(1,0,0,1,0,1,0), 3, 32'hAAAA, "R6 pos");
    run(mk(1,0,0,1,2,0,0), 3, 32'hAAAA, "R6 site2");
    run(mk(1,0,0,1,3,0,0), 3, 32'hAAAA, "R6 site3");
  endtask

  task automatic t_range;
    bus_wr(A_DAT, 32'h0000_BBBB);
    run(mk(1,0,0,1,0,0,6), 3, 32'hBBBB, "R7 mb rd");
    run(mk(1,1,0,1,0,0,6), 3, 32'hBBBB, "R7 mb wr");
    run(mk(1,0,0,1,1,0,3), 3, 32'hBBBB, "R7 db rd");
    run(mk(1,1,0,1,1,0,3), 3, 32'hBBBB, "R7 db wr");
    run(mk(1,0,0,1,1,0,0), 1, 60000000, "R7 db0 intact");
    run(mk(1,0,0,1,0,0,0), 1, 50000000, "R7 mb0 intact");
  endtask

  task automatic t_volt;
    run(mk(1,0,0,2,0,0,0), 1, 3300000, "R8 mb");
    run(mk(1,0,0,2,1,0,0), 1, 900000, "R8 db0");
    run(mk(1,0,0,2,1,0,1), 1, 1000000, "R8 db1");
    run(mk(1,0,0,2,1,0,2), 3, 1000000, "R8 db range");
    run(mk(1,0,0,2,0,0,1), 3, 1000000, "R8 mb dev1");
    run(mk(1,1,0,2,0,0,0), 3, 1000000, "R8 write");
  endtask

  task automatic t_actions;
    bus_wr(A_DAT, 32'h5);
    run(mk(1,1,0,7,0,0,0), 1, 5, "R9 mux");
    run(mk(1,0,0,7,0,0,0), 3, 5, "R9 mux rd");
    run(mk(1,1,0,11,0,0,0), 1, 5, "R9 dvi");
    run(mk(1,1,0,11,1,0,0), 3, 5, "R9 dvi site1");
    run(mk(1,1,0,9,0,0,1), 3, 5, "R9 boot dev1");
    run(mk(1,1,0,3,0,0,0), 3, 5, "R9 fn3");
    run(mk(1,0,0,0,0,0,0), 3, 5, "R9 fn0");
  endtask

  task automatic t_pulse;
    logic [31:0] v;
    bus_wr(A_CMD, mk(1,1,0,8,0,0,0));
    chk("R10 off high", {31'd0, shutdown_o}, 1);
    chk("R10 boot quiet", {31'd0, reboot_o}, 0);
    @(negedge clk_i);
    chk("R10 off single", {31'd0, shutdown_o}, 0);
    bus_wr(A_CMD, mk(1,1,0,9,0,0,0));
    chk("R10 boot high", {31'd0, reboot_o}, 1);
    chk("R10 off quiet", {31'd0, shutdown_o}, 0);
    @(negedge clk_i);
    chk("R10 boot single", {31'd0, reboot_o}, 0);
    bus_wr(A_CMD, mk(1,0,0,8,0,0,0));
    chk("R10 read no pulse", {31'd0, shutdown_o}, 0);
    bus_rd(A_STA, v); chk("R10 read fail", v, 3);
  endtask

  task automatic t_stat;
    logic [31:0] v;
    bus_wr(A_STA, 32'hFFFF_FFFF);
    bus_rd(A_STA, v); chk("R11 keep", v, 3);
    bus_wr(A_STA, 32'h0000_0006);
    bus_rd(A_STA, v); chk("R11 drop", v, 2);
  endtask

  task automatic t_board;
    logic [31:0] v;
    bus_wr(A_STA, 0);
    bus_wr(A_DAT, 32'h0000_0042);
    board_en_i = 1'b0;
    bus_rd(A_DAT, v); chk("R12 rd zero", v, 0);
    bus_wr(A_DAT, 32'h0000_0055);
    bus_wr(A_CMD, mk(1,1,0,8,0,0,0));
    chk("R12 no pulse", {31'd0, shutdown_o}, 0);
    board_en_i = 1'b1;
    bus_rd(A_DAT, v); chk("R12 data kept", v, 32'h42);
    bus_rd(A_STA, v); chk("R12 stat kept", v, 0);
    bus_rd(A_CMD, v); chk("R12 cmd kept", v, mk(0,0,0,8,0,0,0));
  endtask

  task automatic t_overlap;
    logic [31:0] v;
    @(negedge clk_i);
    wr_i = 1'b1; addr_i = A_CMD; wdata_i = mk(1,1,0,8,0,0,0);
    @(negedge clk_i);
    wdata_i = mk(1,0,0,1,0,0,1);
    chk("R10 overlap pulse", {31'd0, shutdown_o}, 1);
    @(negedge clk_i);
    wr_i = 1'b0;
    chk("R10 overlap fall", {31'd0, shutdown_o}, 0);
    bus_rd(A_STA, v); chk("R3 overlap stat", v, 1);
    bus_rd(A_DAT, v); chk("R4 overlap data", v, 23750000);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_ctrl_mask();
    t_osc();
    t_route();
    t_range();
    t_volt();
    t_actions();
    t_pulse();
    t_stat();
    t_board();
    t_overlap();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule